// File: doc/BRIEF.md
# Programmable-Word SPI Master

This block is a register-mapped SPI master. Software programs a mode word (enable, clock phase, idle clock level, bit order, internal loopback, word length and clock divider), then writes the transmit data register. That write starts one word on `mosi` and collects the same number of bits from `miso`. At the end of the word the received bits are stored in the receive data register and an event flag is raised. The flag can drive an interrupt through a mask register. A slave-select register drives the native chip-select lines directly. A read-only capability word tells software the widest word and how many select lines exist.

Data sits in 32-bit registers at bit positions that depend on the bit order. Words of 16 bits or fewer that go MSB first are left-justified for transmit and land at bit 16 on receive. Words that go LSB first are right-justified for transmit and end at bit 15 on receive. A 32-bit word is passed through with no shift. Access goes over a single-cycle register bus. It has no back-pressure: every access is accepted in the cycle in which `bus_sel` is high. Reads return combinationally in the same cycle. Writes take effect at the next clock edge.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the mode register reads 0, the event register reads 0x2 (transmit-not-full set, receive-not-empty clear) and the mask register reads 0. `sclk`, `mosi` and `irq` are low, and every `ss_n` line is high.
- R2: The word length is mode bits [11:8] plus one, and a field of 0 means 32 bits. A word produces exactly that many leading clock edges on `sclk`.
- R3: With MSB-first order (mode bit 3 = 1) and a length L of 16 or less, the bits sent are transmit register bits 31 down to 32-L, highest first. The received word is stored with its LSB at bit 16 of the receive register.
- R4: With LSB-first order (mode bit 3 = 0) and L of 16 or less, the bits sent are transmit register bits 0 up to L-1, lowest first. The received word is stored with its MSB at bit 15 (receive register = word shifted left by 16-L).
- R5: With a 32-bit word, transmit and receive registers are used unshifted in either bit order.
- R6: The event register (address 1) has receive-not-empty at bit 0 and transmit-not-full at bit 1. A transmit write (address 3) while enabled (mode bit 0) and idle clears bit 1. The end of the word sets both bits. Writing a one to a bit clears it.
- R7: `irq` is high exactly while mask bit 0 (address 2) and receive-not-empty are both set. Writing 0 to the mask lowers it.
- R8: The slave-select register (address 5) resets to all ones and drives `ss_n` bit for bit. A cleared bit asserts its line. `ss_n` changes only on a write to that address.
- R9: The capability register (address 6) reads the maximum word length minus one in bits [4:0], a select-present flag in bit 8 and the select-line count in bits [23:16].
- R10: With loopback (mode bit 4) set, `miso` is ignored and the received word equals the transmitted word.
- R11: While idle, `sclk` rests at mode bit 2. With phase bit (mode bit 1) clear, data is sampled on the leading edge. With it set, data is sampled on the trailing edge. Successive `sclk` edges are spaced by mode bits [19:16] plus one clock cycles.
- R12: Clearing the enable bit aborts a word in progress: `sclk` returns to idle, transmit-not-full is set and receive-not-empty stays clear. A transmit write while disabled starts nothing and changes no event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The hardest case to reach from the ports is a word cut short in mid-flight. Clearing the enable bit must return the clock to idle and restore transmit-not-full without raising receive-not-empty. The stimulus reaches this case by programming a slow divider and a 16-bit word, starting the word, and rewriting the mode register with enable clear about twenty cycles later. At that point several edges have passed but the word is far from done. A second hard case is proving that `miso` is ignored in loopback. The bench drives the complement of the expected bits on `miso` during loopback words, so any leak corrupts the received register.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    A_MODE  = 3'd0,
    A_EVENT = 3'd1,
    A_MASK  = 3'd2,
    A_TXD   = 3'd3,
    A_RXD   = 3'd4,
    A_SSEL  = 3'd5,
    A_CAP   = 3'd6
  } spim_addr_e;

  typedef struct packed {
    logic [11:0] rsv_hi;
    logic [3:0]  div;
    logic [3:0]  rsv_mid;
    logic [3:0]  len_m1;
    logic [2:0]  rsv_lo;
    logic        loop;
    logic        msb_first;
    logic        cpol;
    logic        cpha;
    logic        en;
  } spim_mode_t;

  localparam logic [31:0] MODE_WMASK = 32'h000F_0F1F;

  function automatic logic [5:0] word_len(input logic [3:0] f);
    return (f == 4'd0) ? 6'd32 : ({2'b00, f} + 6'd1);
  endfunction

  function automatic logic [31:0] tx_extract(input logic [31:0] r,
                                             input logic [5:0] n,
                                             input logic msb);
    if (n >= 6'd17) return r;
    if (msb) return r >> (6'd32 - n);
    return r & ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [31:0] rx_place(input logic [31:0] w,
                                           input logic [5:0] n,
                                           input logic msb);
    if (n >= 6'd17) return w;
    if (msb) return w << 16;
    return w << (6'd16 - n);
  endfunction

endpackage

// File: rtl/spim_prescale.sv
module spim_prescale #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [W-1:0]  tx_word,
  input  logic [LW-1:0] len,
  input  logic          msb,
  input  logic          cpha,
  input  logic          cpol,
  input  logic          loop,
  input  logic          miso,
  input  logic          tick,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rx_word,
  output logic          sclk,
  output logic          mosi
);
  localparam int CW = LW + 1;
  localparam int IW = $clog2(W);

  logic [W-1:0]  txs_q, rxs_q;
  logic [CW-1:0] edge_q;
  logic          tog_q, busy_q, done_q;
  logic [IW-1:0] top_idx;
  logic          tx_bit, in_bit, lead, do_samp, do_shift, last_edge, step;

  always_comb begin
    top_idx   = IW'(len - LW'(1));
    tx_bit    = msb ? txs_q[top_idx] : txs_q[0];
    in_bit    = loop ? tx_bit : miso;
    lead      = !tog_q;
    do_samp   = cpha ? !lead : lead;
    do_shift  = cpha ? (lead && (edge_q != '0)) : !lead;
    last_edge = (edge_q == (CW'({len, 1'b0}) - CW'(1)));
    step      = busy_q && !done_q && tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q  <= '0;
      rxs_q  <= '0;
      edge_q <= '0;
      tog_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tog_q  <= 1'b0;
      edge_q <= '0;
    end else if (done_q) begin
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      txs_q  <= tx_word;
      rxs_q  <= '0;
      tog_q  <= 1'b0;
      edge_q <= '0;
    end else if (step) begin
      tog_q  <= !tog_q;
      edge_q <= edge_q + CW'(1);
      if (do_samp) begin
        if (msb) rxs_q <= {rxs_q[W-2:0], in_bit};
        else     rxs_q <= (rxs_q >> 1) | (W'(in_bit) << top_idx);
      end
      if (do_shift) begin
        if (msb) txs_q <= txs_q << 1;
        else     txs_q <= txs_q >> 1;
      end
      if (last_edge) done_q <= 1'b1;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rxs_q;
  assign sclk    = cpol ^ tog_q;
  assign mosi    = busy_q && tx_bit;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NSS     = 4,
  parameter int MAX_LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [2:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n
);
  localparam int LW = 6;
  localparam logic [31:0] CAP_VAL =
    {8'h00, 8'(NSS), 7'h00, (NSS > 0), 3'h0, 5'(MAX_LEN - 1)};

  spim_mode_t     mode_q;
  logic           rx_ne_q, tx_nf_q, irq_en_q;
  logic [31:0]    rxd_q;
  logic [NSS-1:0] ss_q;

  logic           wr, start, busy, done, tick, abort;
  logic [LW-1:0]  len;
  logic [31:0]    tx_word, rx_word;

  assign wr    = bus_sel && bus_we;
  assign abort = !mode_q.en;
  assign len   = word_len(mode_q.len_m1);
  assign start = wr && (bus_addr == A_TXD) && mode_q.en && !busy;
  assign tx_word = tx_extract(bus_wdata, len, mode_q.msb_first);

  spim_prescale #(.DIV_W(4)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy && !done),
    .div  (mode_q.div),
    .tick (tick)
  );

  spim_shifter #(.W(WORD_W), .LW(LW)) u_shf (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (abort),
    .tx_word(tx_word),
    .len    (len),
    .msb    (mode_q.msb_first),
    .cpha   (mode_q.cpha),
    .cpol   (mode_q.cpol),
    .loop   (mode_q.loop),
    .miso   (miso),
    .tick   (tick),
    .busy   (busy),
    .done   (done),
    .rx_word(rx_word),
    .sclk   (sclk),
    .mosi   (mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      rx_ne_q  <= 1'b0;
      tx_nf_q  <= 1'b1;
      irq_en_q <= 1'b0;
      rxd_q    <= '0;
      ss_q     <= '1;
    end else begin
      if (wr && bus_addr == A_MODE) mode_q <= spim_mode_t'(bus_wdata & MODE_WMASK);
      if (wr && bus_addr == A_MASK) irq_en_q <= bus_wdata[0];
      if (wr && bus_addr == A_SSEL) ss_q <= bus_wdata[NSS-1:0];
      if (wr && bus_addr == A_EVENT) begin
        if (bus_wdata[0]) rx_ne_q <= 1'b0;
        if (bus_wdata[1]) tx_nf_q <= 1'b0;
      end
      if (start) tx_nf_q <= 1'b0;
      if (abort && busy) tx_nf_q <= 1'b1;
      if (done && !abort) begin
        rx_ne_q <= 1'b1;
        tx_nf_q <= 1'b1;
        rxd_q   <= rx_place(rx_word, len, mode_q.msb_first);
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_EVENT: bus_rdata = {30'h0, tx_nf_q, rx_ne_q};
      A_MASK:  bus_rdata = {31'h0, irq_en_q};
      A_RXD:   bus_rdata = rxd_q;
      A_SSEL:  bus_rdata = 32'(ss_q);
      A_CAP:   bus_rdata = CAP_VAL;
      default: bus_rdata = '0;
    endcase
  end

  assign irq  = irq_en_q && rx_ne_q;
  assign ss_n = ss_q;
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int NSS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           sclk,
  input logic           mosi,
  input logic           cpol,
  input logic           en,
  input logic           tx_nf,
  input logic           rx_ne,
  input logic [NSS-1:0] ss_n,
  input logic           ss_wr
);
  // R11: clock rests at the programmed idle level
  p_idle_sclk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  // R1: data line low when no word is in flight
  p_idle_mosi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  // R6: transmit-not-full stays clear during a word
  p_txnf_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_nf);

  // R6: receive-not-empty rises only at the end of a word
  p_rxne_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ne) |-> $past(busy));

  // R8: selects move only on a register write
  p_ss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_wr |=> $stable(ss_n));

  // R12: disabling stops the shifter
  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind spim_ctrl spim_ctrl_chk #(.NSS(NSS)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .busy (busy),
  .sclk (sclk),
  .mosi (mosi),
  .cpol (mode_q.cpol),
  .en   (mode_q.en),
  .tx_nf(tx_nf_q),
  .rx_ne(rx_ne_q),
  .ss_n (ss_n),
  .ss_wr(bus_sel && bus_we && (bus_addr == 3'd5))
);

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NSS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, sclk, mosi, miso;
  logic [NSS-1:0] ss_n;

  always #(CLK_P/2) clk = ~clk;

  spim_ctrl #(.NSS(NSS)) u_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int sl_epoch = 0, seen_epoch = 0;
  bit cpha_c = 0, cpol_c = 0, msb_c = 0;
  int pm_c = 0;
  logic [31:0] miso_bits = '0;
  int k = 0, edges_lead = 0, gap = 0, gap_err = 0;
  bit gap_valid = 0, sl_lead = 0;
  logic prev_sclk = 1'b0;
  logic [31:0] cap_w = '0;

  assign miso = miso_bits[k[4:0]];

  always @(negedge clk) begin
    if (sl_epoch != seen_epoch) begin
      seen_epoch = sl_epoch;
      k = 0; edges_lead = 0; gap = 0; gap_err = 0; gap_valid = 0;
      cap_w = '0; prev_sclk = sclk;
    end else if (sclk !== prev_sclk) begin
      sl_lead = (prev_sclk == cpol_c);
      if (sl_lead) edges_lead++;
      if (gap_valid && gap != pm_c) gap_err++;
      gap = 0; gap_valid = 1;
      if ((cpha_c == 0) == sl_lead) begin
        if (msb_c) cap_w = {cap_w[30:0], mosi};
        else if (k < 32) cap_w[k[4:0]] = mosi;
        k++;
      end
      prev_sclk = sclk;
    end else begin
      gap++;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  // ---------------- scoreboard ----------------
  string       q_tag[$];
  logic [31:0] q_rx[$], q_mosi[$];
  int          q_len[$];
  logic [31:0] act_rx;
  event        mon_ev;

  initial begin
    forever begin
      string t; logic [31:0] er, em; int n;
      @(mon_ev);
      t = q_tag.pop_front(); er = q_rx.pop_front();
      em = q_mosi.pop_front(); n = q_len.pop_front();
      check({t, " rx register"}, act_rx, er);
      check({t, " mosi bits"}, cap_w & lmask(n), em);
      check("R2 leading edge count", edges_lead, n);
      check("R11 edge spacing", gap_err, 0);
    end
  end

  task automatic poll_rx(input string tag);
    logic [31:0] v;
    bit ok = 0;
    for (int n = 0; n < 3000; n++) begin
      bus_read(3'd1, v);
      if (v[0]) begin ok = 1; break; end
    end
    if (!ok) check({tag, " word completion"}, 0, 1);
  endtask

  task automatic xfer(input string tag, input int lenf, input bit msb, input bit cpha,
                      input bit cpol, input bit loop, input int pm,
                      input logic [31:0] txr, input logic [31:0] sw);
    int L;
    logic [31:0] mode, w, rw, er;
    L = (lenf == 0) ? 32 : lenf + 1;
    mode = (32'(pm) << 16) | (32'(lenf) << 8) | (32'(loop) << 4) |
           (32'(msb) << 3) | (32'(cpol) << 2) | (32'(cpha) << 1);
    bus_write(3'd0, mode);
    bus_write(3'd0, mode | 32'h1);
    bus_write(3'd1, 32'h1);
    cpha_c = cpha; cpol_c = cpol; msb_c = msb; pm_c = pm;
    w = (L == 32) ? txr : (msb ? (txr >> (32 - L)) : (txr & lmask(L)));
    rw = loop ? w : (sw & lmask(L));
    miso_bits = '0;
    for (int i = 0; i < L; i++) begin
      logic b;
      b = msb ? rw[L-1-i] : rw[i];
      miso_bits[i] = loop ? ~b : b;
    end
    sl_epoch++;
    @(negedge clk);
    er = (L == 32) ? rw : (msb ? (rw << 16) : (rw << (16 - L)));
    q_tag.push_back(tag); q_rx.push_back(er); q_mosi.push_back(w); q_len.push_back(L);
    bus_write(3'd3, txr);
    poll_rx(tag);
    bus_read(3'd4, act_rx);
    -> mon_ev;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] v, pre;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_read(3'd0, v); check("R1 mode reset", v, 32'h0);
    bus_read(3'd1, v); check("R1 event reset", v, 32'h2);
    bus_read(3'd2, v); check("R1 mask reset", v, 32'h0);
    check("R1 ss_n reset", 32'(ss_n), 32'hF);
    check("R1 sclk reset", 32'(sclk), 0);
    check("R1 mosi reset", 32'(mosi), 0);
    check("R1 irq reset", 32'(irq), 0);

    // R9 capability
    bus_read(3'd6, v); check("R9 capability", v, 32'h0004_011F);

    // R8 select lines
    bus_write(3'd5, 32'hA);
    check("R8 ss_n drive", 32'(ss_n), 32'hA);
    bus_read(3'd5, v); check("R8 ss readback", v, 32'hA);
    bus_write(3'd5, 32'hF);

    // transfers through the scoreboard
    xfer("R3 msb 8b",   7,  1, 0, 0, 0, 1, 32'hA500_0000, 32'h3C);
    xfer("R4 lsb 5b",   4,  0, 1, 1, 0, 0, 32'h0000_0013, 32'h19);
    xfer("R3 msb 16b",  15, 1, 1, 0, 0, 2, 32'hBEEF_0000, 32'h1234);
    xfer("R4 lsb 16b",  15, 0, 0, 0, 0, 1, 32'h0000_5A3C, 32'hC3E1);
    xfer("R5 lsb 32b",  0,  0, 0, 1, 0, 0, 32'hCAFE_F00D, 32'h8765_4321);
    xfer("R5 msb 32b",  0,  1, 1, 0, 0, 0, 32'h1357_9BDF, 32'h2468_ACE0);
    xfer("R10 loop msb 12b", 11, 1, 0, 0, 1, 0, 32'hABC0_0000, 32'h0);
    xfer("R10 loop lsb 4b",  3,  0, 1, 1, 1, 1, 32'h0000_0009, 32'h0);

    // R6 / R7 events and interrupt
    bus_write(3'd2, 32'h1);
    bus_write(3'd0, 32'h0003_0708);
    bus_write(3'd0, 32'h0003_0709);
    bus_write(3'd1, 32'h3);
    bus_write(3'd3, 32'h5500_0000);
    bus_read(3'd1, v); check("R6 tx_nf cleared by transmit write", v, 32'h0);
    check("R7 irq low while pending", 32'(irq), 0);
    poll_rx("R6 event word");
    bus_read(3'd1, v); check("R6 both flags at word end", v, 32'h3);
    check("R7 irq with mask and rx_ne", 32'(irq), 1);
    bus_write(3'd1, 32'h2);
    bus_read(3'd1, v); check("R6 w1c tx_nf only", v, 32'h1);
    bus_write(3'd1, 32'h1);
    bus_read(3'd1, v); check("R6 w1c rx_ne", v, 32'h0);
    check("R7 irq drops with rx_ne", 32'(irq), 0);
    bus_write(3'd3, 32'h0F00_0000);
    poll_rx("R7 second word");
    check("R7 irq raised again", 32'(irq), 1);
    bus_write(3'd2, 32'h0);
    check("R7 mask zero disables irq", 32'(irq), 0);

    // R12 transmit write while disabled
    bus_write(3'd0, 32'h0000_0708);
    bus_read(3'd1, pre);
    sl_epoch++;
    @(negedge clk);
    bus_write(3'd3, 32'hFF00_0000);
    repeat (50) @(negedge clk);
    bus_read(3'd1, v); check("R12 disabled write leaves events", v, pre);
    check("R12 disabled write no clock", edges_lead, 0);

    // R12 abort mid-word, R11 idle level with cpol=1
    bus_write(3'd0, 32'h0003_0F04);
    bus_write(3'd0, 32'h0003_0F05);
    bus_write(3'd1, 32'h3);
    bus_write(3'd3, 32'hFFFF_0000);
    repeat (20) @(negedge clk);
    bus_write(3'd0, 32'h0003_0F04);
    repeat (2) @(negedge clk);
    check("R11 sclk idle high after abort", 32'(sclk), 1);
    check("R12 mosi low after abort", 32'(mosi), 0);
    bus_read(3'd1, v); check("R12 abort event state", v, 32'h2);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule